// File: doc/BRIEF.md
# GPIO Interrupt Detection Controller

This block turns eight already-synchronized general-purpose input pins into interrupt events. Each pin has its own detector that runs in one of three detection modes: single-edge (rising or falling), dual-edge, or level (active high or active low). The detector keeps one raw status bit per pin. An enable mask gates the raw bits into a masked status, and the single interrupt line is the OR of the masked bits.

Software sets up and services the block through byte-wide registers on a simple register bus. The bus has a 12-bit address, 8-bit write data, one-cycle write and read strobes, and registered 8-bit read data. A typical interrupt handler reads the masked status, then writes that value to the clear register. This acknowledges the edge-type sources it is about to service.

Each pin detector is a small mode machine whose state is decoded from three configuration bits. The sense bit selects the `DET_LEVEL` state when set. When the sense bit is clear, the dual-edge bit selects `DET_EDGE_BOTH` if set and `DET_EDGE_ONE` if not. A configuration write takes effect at the next clock edge, so the pin moves between these states in that cycle. In `DET_EDGE_ONE` and `DET_EDGE_BOTH` the raw bit is sticky: a qualifying edge sets it, and a clear write resets it. In `DET_LEVEL` the raw bit is recomputed every cycle. When a pin moves from `DET_LEVEL` to an edge state, its raw bit keeps its last value.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every configuration register and every raw and masked status bit reads 0, and `irq_out` is 0.
- R2: The registers at 0x404 (sense: 1=level, 0=edge), 0x408 (dual-edge: 1=both edges), 0x40C (polarity: 1=rising/high, 0=falling/low) and 0x410 (enable: 1=enabled) read back the last value written. Read data appears on `rdata` in the cycle after `rd_en`. Any unmapped address reads 0, and writes to it have no effect.
- R3: With sense=0, dual-edge=0 and polarity=1, a 0-to-1 change of a pin sets its raw bit (0x414) at the clock edge that samples the new pin value. A 1-to-0 change leaves the raw bit unchanged.
- R4: With sense=0, dual-edge=0 and polarity=0, a 1-to-0 change sets the raw bit, and a 0-to-1 change leaves it unchanged.
- R5: With sense=0 and dual-edge=1, either change sets the raw bit, whatever the polarity bit holds.
- R6: With sense=1, the raw bit equals 1 exactly when the pin equals its polarity bit. It follows one clock after the pin or the polarity bit changes.
- R7: The masked status at 0x418 equals raw AND enable. `irq_out` is 1 exactly when some masked bit is 1.
- R8: Writing to 0x41C clears the edge-mode raw bits whose write-data bit is 1, and leaves the bits written as 0 unchanged. 0x41C reads 0. The raw and masked status registers are read-only.
- R9: A write to 0x41C has no effect on a pin in level mode.
- R10: If a qualifying edge arrives in the same cycle as a clear of that pin's bit, the raw bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 8 | Synchronized pin levels |
| addr | input | 12 | Register byte address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rdata | output | 8 | Registered read data, valid the cycle after `rd_en` |
| irq_out | output | 1 | Combined interrupt, high while any masked status bit is set |

## Verification
A configuration write or clear write takes effect at the clock edge that samples its strobe. A pin change reaches the raw bit at the first edge that samples the new pin level, and `irq_out` follows that same edge through logic alone. A level-mode bit that depends on a polarity change settles one edge after that register is written. Read data lands one edge after `rd_en`. The bench drives every input on the falling edge and checks `irq_out` on the following falling edge. It checks `rdata` one falling edge after the read strobe, and it inserts an idle cycle where a level bit needs its extra edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int ADDR_W = 12;

    // Register byte offsets
    localparam logic [ADDR_W-1:0] OFS_SENSE = 12'h404;
    localparam logic [ADDR_W-1:0] OFS_BOTH  = 12'h408;
    localparam logic [ADDR_W-1:0] OFS_EVENT = 12'h40C;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h410;
    localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h414;
    localparam logic [ADDR_W-1:0] OFS_MIS   = 12'h418;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 12'h41C;

    // Detection mode of one pin
    typedef enum logic [1:0] {
        DET_EDGE_ONE  = 2'd0,
        DET_EDGE_BOTH = 2'd1,
        DET_LEVEL     = 2'd2
    } det_mode_e;

endpackage

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic sense,
    input  logic both,
    input  logic ev,
    input  logic clr,
    output logic raw
);

    det_mode_e mode;
    logic      pin_d;
    logic      raw_q;
    logic      raw_d;
    logic      kept;

    // Mode selection: sense wins, then dual-edge
    always_comb begin
        if (sense)
            mode = DET_LEVEL;
        else if (both)
            mode = DET_EDGE_BOTH;
        else
            mode = DET_EDGE_ONE;
    end

    // Sticky part of the edge state, after any clear
    assign kept = raw_q & ~clr;

    // Next raw value per mode
    always_comb begin
        unique case (mode)
            DET_LEVEL:     raw_d = (pin == ev);
            DET_EDGE_BOTH: raw_d = kept | (pin ^ pin_d);
            DET_EDGE_ONE:  raw_d = kept | (ev ? (pin & ~pin_d) : (~pin & pin_d));
            default:       raw_d = 1'b0;
        endcase
    end

    // State registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_d <= 1'b0;
            raw_q <= 1'b0;
        end else begin
            pin_d <= pin;
            raw_q <= raw_d;
        end
    end

    assign raw = raw_q;

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_PINS-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [N_PINS-1:0] raw,
    output logic [N_PINS-1:0] sense,
    output logic [N_PINS-1:0] both,
    output logic [N_PINS-1:0] ev,
    output logic [N_PINS-1:0] ie,
    output logic [N_PINS-1:0] clr,
    output logic [N_PINS-1:0] rdata
);

    logic [N_PINS-1:0] rd_mux;

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense <= '0;
            both  <= '0;
            ev    <= '0;
            ie    <= '0;
        end else if (wr_en) begin
            unique case (addr)
                OFS_SENSE: sense <= wdata;
                OFS_BOTH:  both  <= wdata;
                OFS_EVENT: ev    <= wdata;
                OFS_MASK:  ie    <= wdata;
                default:   ;
            endcase
        end
    end

    // Clear pulse, one cycle wide
    assign clr = (wr_en && addr == OFS_CLR) ? wdata : '0;

    // Read selection
    always_comb begin
        unique case (addr)
            OFS_SENSE: rd_mux = sense;
            OFS_BOTH:  rd_mux = both;
            OFS_EVENT: rd_mux = ev;
            OFS_MASK:  rd_mux = ie;
            OFS_RAW:   rd_mux = raw;
            OFS_MIS:   rd_mux = raw & ie;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_mux;
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_PINS-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [N_PINS-1:0] rdata,
    output logic              irq_out
);

    logic [N_PINS-1:0] sense_q;
    logic [N_PINS-1:0] both_q;
    logic [N_PINS-1:0] ev_q;
    logic [N_PINS-1:0] ie_q;
    logic [N_PINS-1:0] clr_bits;
    logic [N_PINS-1:0] raw_q;

    gpio_irq_regs #(.N_PINS(N_PINS)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .wdata (wdata),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .raw   (raw_q),
        .sense (sense_q),
        .both  (both_q),
        .ev    (ev_q),
        .ie    (ie_q),
        .clr   (clr_bits),
        .rdata (rdata)
    );

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        gpio_irq_pin u_pin (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pin_in[g]),
            .sense (sense_q[g]),
            .both  (both_q[g]),
            .ev    (ev_q[g]),
            .clr   (clr_bits[g]),
            .raw   (raw_q[g])
        );
    end

    assign irq_out = |(raw_q & ie_q);

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_PINS-1:0] pin_in,
    input logic [ADDR_W-1:0] addr,
    input logic [N_PINS-1:0] wdata,
    input logic              wr_en,
    input logic              rd_en,
    input logic [N_PINS-1:0] rdata,
    input logic              irq_out,
    input logic [N_PINS-1:0] sense,
    input logic [N_PINS-1:0] both,
    input logic [N_PINS-1:0] ev,
    input logic [N_PINS-1:0] ie,
    input logic [N_PINS-1:0] raw
);

    logic [N_PINS-1:0] pin_prev;
    logic [N_PINS-1:0] rise;
    logic [N_PINS-1:0] fall;
    logic [N_PINS-1:0] qual;
    logic [N_PINS-1:0] clr_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pin_prev <= '0;
        else
            pin_prev <= pin_in;
    end

    assign rise    = pin_in & ~pin_prev;
    assign fall    = ~pin_in & pin_prev;
    assign qual    = (both & (rise | fall)) | (~both & ev & rise) | (~both & ~ev & fall);
    assign clr_req = (wr_en && addr == OFS_CLR) ? wdata : '0;

    for (genvar i = 0; i < N_PINS; i++) begin : g_chk
        // R3 R4 R5 R10
        edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!sense[i] && qual[i]) |=> raw[i]);

        // R8
        edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!sense[i] && !qual[i] && clr_req[i]) |=> !raw[i]);

        // R3
        edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!sense[i] && !qual[i] && !clr_req[i]) |=> (raw[i] == $past(raw[i])));

        // R6
        level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sense[i] |=> (raw[i] == ($past(pin_in[i]) == $past(ev[i]))));
    end

    // R7
    masked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFS_MIS) |=> (rdata == $past(raw & ie)));

    // R7
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ie == '0) |-> !irq_out);

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.N_PINS(N_PINS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_in  (pin_in),
    .addr    (addr),
    .wdata   (wdata),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rdata   (rdata),
    .irq_out (irq_out),
    .sense   (sense_q),
    .both    (both_q),
    .ev      (ev_q),
    .ie      (ie_q),
    .raw     (raw_q)
);

// File: tb/gpio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb;

    localparam logic [11:0] A_SENSE = 12'h404;
    localparam logic [11:0] A_BOTH  = 12'h408;
    localparam logic [11:0] A_EVENT = 12'h40C;
    localparam logic [11:0] A_MASK  = 12'h410;
    localparam logic [11:0] A_RAW   = 12'h414;
    localparam logic [11:0] A_MIS   = 12'h418;
    localparam logic [11:0] A_CLR   = 12'h41C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pins = '0;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_irq_ctrl u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pins),
        .addr    (addr),
        .wdata   (wdata),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .rdata   (rdata),
        .irq_out (irq_out)
    );

    task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic check_irq(string req, logic exp);
        checks++;
        if (irq_out !== exp) begin
            errors++;
            $display("FAIL %s: irq_out actual %0b expected %0b", req, irq_out, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [11:0] a, logic [7:0] exp);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check8(req, rdata, exp);
    endtask

    task automatic pin_set(int idx, logic v);
        @(negedge clk);
        pins[idx] = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        // R1
        check_irq("R1", 1'b0);
        rd_chk("R1", A_SENSE, 8'h00);
        rd_chk("R1", A_BOTH,  8'h00);
        rd_chk("R1", A_EVENT, 8'h00);
        rd_chk("R1", A_MASK,  8'h00);
        rd_chk("R1", A_RAW,   8'h00);
        rd_chk("R1", A_MIS,   8'h00);
    endtask

    task automatic t_config();
        // R2: readback, unmapped; R8: read-only status, clear reads 0
        wr(A_EVENT, 8'hFF);
        wr(A_SENSE, 8'hA5);
        wr(A_BOTH,  8'h3C);
        wr(A_MASK,  8'h81);
        rd_chk("R2", A_SENSE, 8'hA5);
        rd_chk("R2", A_BOTH,  8'h3C);
        rd_chk("R2", A_EVENT, 8'hFF);
        rd_chk("R2", A_MASK,  8'h81);
        wr(12'h400, 8'h77);
        rd_chk("R2", 12'h400, 8'h00);
        wr(A_RAW, 8'hFF);
        rd_chk("R8", A_RAW, 8'h00);
        rd_chk("R8", A_CLR, 8'h00);
        wr(A_SENSE, 8'h00);
        wr(A_BOTH,  8'h00);
        wr(A_EVENT, 8'h00);
        wr(A_MASK,  8'h00);
        rd_chk("R2", A_MASK, 8'h00);
    endtask

    task automatic t_rising();
        wr(A_EVENT, 8'h01);
        wr(A_MASK,  8'hFF);
        pin_set(0, 1'b1);
        check_irq("R3", 1'b1);
        rd_chk("R3", A_RAW, 8'h01);
        wr(A_CLR, 8'h01);
        rd_chk("R8", A_RAW, 8'h00);
        pin_set(0, 1'b0);
        check_irq("R3", 1'b0);
        rd_chk("R3", A_RAW, 8'h00);
    endtask

    task automatic t_falling();
        pin_set(1, 1'b1);
        rd_chk("R4", A_RAW, 8'h00);
        pin_set(1, 1'b0);
        check_irq("R4", 1'b1);
        rd_chk("R4", A_RAW, 8'h02);
        wr(A_CLR, 8'h02);
        rd_chk("R8", A_RAW, 8'h00);
    endtask

    task automatic t_both();
        wr(A_BOTH, 8'h04);
        pin_set(2, 1'b1);
        rd_chk("R5", A_RAW, 8'h04);
        wr(A_CLR, 8'h04);
        rd_chk("R5", A_RAW, 8'h00);
        pin_set(2, 1'b0);
        rd_chk("R5", A_RAW, 8'h04);
        wr(A_CLR, 8'h04);
        rd_chk("R5", A_RAW, 8'h00);
    endtask

    task automatic t_mask();
        logic [7:0] pend;
        wr(A_MASK, 8'h00);
        pin_set(3, 1'b1);
        pin_set(3, 1'b0);
        rd_chk("R7", A_RAW, 8'h08);
        rd_chk("R7", A_MIS, 8'h00);
        check_irq("R7", 1'b0);
        wr(A_MASK, 8'h08);
        check_irq("R7", 1'b1);
        rd_chk("R7", A_MIS, 8'h08);
        wr(A_CLR, 8'hF7);
        rd_chk("R8", A_RAW, 8'h08);
        pend = rdata;
        wr(A_CLR, pend);
        rd_chk("R8", A_RAW, 8'h00);
        check_irq("R8", 1'b0);
    endtask

    task automatic t_level();
        wr(A_MASK,  8'h10);
        wr(A_EVENT, 8'h11);
        wr(A_SENSE, 8'h10);
        rd_chk("R6", A_RAW, 8'h00);
        pin_set(4, 1'b1);
        check_irq("R6", 1'b1);
        rd_chk("R6", A_RAW, 8'h10);
        wr(A_CLR, 8'h10);
        rd_chk("R9", A_RAW, 8'h10);
        pin_set(4, 1'b0);
        check_irq("R6", 1'b0);
        rd_chk("R6", A_RAW, 8'h00);
        wr(A_EVENT, 8'h01);
        @(negedge clk);
        rd_chk("R6", A_RAW, 8'h10);
        wr(A_SENSE, 8'h00);
        wr(A_CLR, 8'h10);
        rd_chk("R8", A_RAW, 8'h00);
    endtask

    task automatic t_race();
        wr(A_BOTH, 8'h20);
        pin_set(5, 1'b1);
        rd_chk("R5", A_RAW, 8'h20);
        @(negedge clk);
        addr = A_CLR; wdata = 8'h20; wr_en = 1'b1; pins[5] = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        rd_chk("R10", A_RAW, 8'h20);
        wr(A_CLR, 8'h20);
        rd_chk("R10", A_RAW, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_config();
        t_rising();
        t_falling();
        t_both();
        t_mask();
        t_level();
        t_race();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule